// File: doc/BRIEF.md
# Dual-Mode Residue Channel / Double-Width Modulo Adder

This block holds two n-bit parallel-prefix adders that serve two residue channels of an arithmetic datapath. In channel mode the low adder adds modulo 2^n−1 and the high adder adds modulo 2^n+1 on diminished-one operands that carry a nonzero flag. The two adders run independently.

In conversion mode the same two adders form one 2n-bit adder modulo 2^(2n)−1. Its operands are a sum vector and a carry vector from an earlier carry-save stage. The carry-in of each half is steered from the group generate and propagate signals of both halves. The low half then receives the end-around carry, and the high half receives the carry out of the low half with that end-around carry included. The result is (A+B+Ω) mod 2^(2n), where Ω is 1 when A+B ≥ 2^(2n)−1. Zero therefore has a single representation. All outputs are registered, with a latency of one clock.

Top module: `dual_mode_mod_adder`

## Requirements
- R1: While `rst` is high at a rising edge, `lo_q`, `hi_q` and `hi_nz_q` are all zero after that edge.
- R2: With `conv`=0 and `x2`,`y2` in 0..2^n−2, `lo_q` equals (x2+y2) mod (2^n−1). The value 2^n−1 never appears, so zero is always all zeros.
- R3: With `conv`=0, a high-channel operand of value v in 0..2^n is given as flag=1 and field=v−1 when v≠0, and as flag=0 and field=0 when v=0. The output pair (`hi_nz_q`, `hi_q`) is the same encoding of (vx+vy) mod (2^n+1).
- R4: With `conv`=1, {`hi_q`,`lo_q`} equals (s_vec+c_vec) mod (2^(2n)−1). This holds for any 2n-bit operands that are not both all ones.
- R5: With `conv`=1 and operands not both all ones, the result is never 2^(2n)−1. A sum equal to 2^(2n)−1 gives all zeros.
- R6: With `conv`=1, the operand flags `x3_nz`/`y3_nz` have no effect on the result, and `hi_nz_q` is 0.
- R7: With `conv`=0, `s_vec` and `c_vec` have no effect on either channel result.
- R8: Each result appears on the outputs at the rising edge after its operands are presented. The outputs hold until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv | input | 1 | 0: two channel adders, 1: one double-width modulo 2^(2n)−1 adder |
| x2 | input | N | Low-channel operand A (modulo 2^n−1) |
| y2 | input | N | Low-channel operand B (modulo 2^n−1) |
| x3 | input | N | High-channel operand A, diminished-one field |
| x3_nz | input | 1 | High-channel operand A nonzero flag |
| y3 | input | N | High-channel operand B, diminished-one field |
| y3_nz | input | 1 | High-channel operand B nonzero flag |
| s_vec | input | 2N | Conversion-mode sum vector |
| c_vec | input | 2N | Conversion-mode carry vector |
| lo_q | output | N | Low-channel result, or low half of the double-width result |
| hi_q | output | N | High-channel diminished-one field, or high half of the double-width result |
| hi_nz_q | output | 1 | High-channel result nonzero flag (0 in conversion mode) |

## Verification
The assertions check the following on every cycle:
- the reset state;
- the absence of an all-ones result in conversion mode;
- the cleared nonzero flag in conversion mode;
- the pass-through and zero-plus-zero behaviour of the diminished-one channel;
- that the low channel never produces its redundant all-ones code.

Only the bench's sweeps can show the full arithmetic, because it needs a modular reference. The bench covers every residue pair of both channels and every operand pair of the double-width adder at a small width. It also checks that the inputs of the inactive mode are ignored.

// File: rtl/dmm_pkg.sv
package dmm_pkg;

    typedef enum logic {
        MODE_CHAN = 1'b0,
        MODE_CONV = 1'b1
    } mode_t;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // prefix operator: hi group absorbs lo group
    function automatic gp_t gp_dot(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/dmm_prefix_adder.sv
module dmm_prefix_adder
    import dmm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output gp_t          grp
);
    localparam int LV = (W > 1) ? $clog2(W) : 1;

    gp_t [LV:0][W-1:0] tr;

    generate
        for (genvar i = 0; i < W; i++) begin : g_leaf
            assign tr[0][i].g = a[i] & b[i];
            assign tr[0][i].p = a[i] ^ b[i];
        end
        for (genvar lv = 0; lv < LV; lv++) begin : g_level
            for (genvar i = 0; i < W; i++) begin : g_node
                if (i >= (1 << lv)) begin : g_op
                    assign tr[lv+1][i] = gp_dot(tr[lv][i], tr[lv][i-(1<<lv)]);
                end else begin : g_pass
                    assign tr[lv+1][i] = tr[lv][i];
                end
            end
        end
    endgenerate

    // extra level absorbing the carry-in
    logic [W:0] cy;
    assign cy[0] = cin;
    generate
        for (genvar i = 0; i < W; i++) begin : g_carry
            assign cy[i+1] = tr[LV][i].g | (tr[LV][i].p & cin);
            assign sum[i]  = tr[0][i].p ^ cy[i];
        end
    endgenerate

    assign grp = tr[LV][W-1];

endmodule

// File: rtl/dmm_carry_steer.sv
module dmm_carry_steer
    import dmm_pkg::*;
(
    input  mode_t mode,
    input  gp_t   lo_grp,
    input  gp_t   hi_grp,
    input  logic  xa_nz,
    input  logic  xb_nz,
    output logic  cin_lo,
    output logic  cin_hi,
    output logic  hi_nz
);
    logic alpha_lo, alpha_hi, beta_lo, beta_hi;

    always_comb begin
        // channel mode: end-around carry, inverted end-around for diminished-one
        alpha_lo = lo_grp.g | lo_grp.p;
        alpha_hi = xa_nz & xb_nz & ~hi_grp.g;
        // conversion mode: cross-coupled carries with single zero
        beta_lo  = hi_grp.g | (hi_grp.p & (lo_grp.g | lo_grp.p));
        beta_hi  = lo_grp.g | (lo_grp.p & (hi_grp.g | hi_grp.p));
        if (mode == MODE_CONV) begin
            cin_lo = beta_lo;
            cin_hi = beta_hi;
            hi_nz  = 1'b0;
        end else begin
            cin_lo = alpha_lo;
            cin_hi = alpha_hi;
            hi_nz  = (xa_nz | xb_nz) & ~(xa_nz & xb_nz & hi_grp.p);
        end
    end

endmodule

// File: rtl/dual_mode_mod_adder.sv
module dual_mode_mod_adder
    import dmm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           conv,
    input  logic [N-1:0]   x2,
    input  logic [N-1:0]   y2,
    input  logic [N-1:0]   x3,
    input  logic           x3_nz,
    input  logic [N-1:0]   y3,
    input  logic           y3_nz,
    input  logic [2*N-1:0] s_vec,
    input  logic [2*N-1:0] c_vec,
    output logic [N-1:0]   lo_q,
    output logic [N-1:0]   hi_q,
    output logic           hi_nz_q
);
    localparam int W2 = 2 * N;

    mode_t        mode;
    logic [N-1:0] u, v, h, f;
    logic [N-1:0] lo_sum, hi_sum;
    gp_t          lo_grp, hi_grp;
    logic         cin_lo, cin_hi, hi_nz;

    assign mode = conv ? MODE_CONV : MODE_CHAN;

    always_comb begin
        if (mode == MODE_CONV) begin
            u = s_vec[N-1:0];
            v = c_vec[N-1:0];
            h = s_vec[W2-1:N];
            f = c_vec[W2-1:N];
        end else begin
            u = x2;
            v = y2;
            h = x3;
            f = y3;
        end
    end

    dmm_prefix_adder #(.W(N)) u_lo (
        .a(u), .b(v), .cin(cin_lo), .sum(lo_sum), .grp(lo_grp)
    );

    dmm_prefix_adder #(.W(N)) u_hi (
        .a(h), .b(f), .cin(cin_hi), .sum(hi_sum), .grp(hi_grp)
    );

    dmm_carry_steer u_steer (
        .mode(mode), .lo_grp(lo_grp), .hi_grp(hi_grp),
        .xa_nz(x3_nz), .xb_nz(y3_nz),
        .cin_lo(cin_lo), .cin_hi(cin_hi), .hi_nz(hi_nz)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            hi_q    <= '0;
            hi_nz_q <= 1'b0;
        end else begin
            lo_q    <= lo_sum;
            hi_q    <= hi_sum;
            hi_nz_q <= hi_nz;
        end
    end

endmodule

// File: rtl/dual_mode_mod_adder_chk.sv
module dual_mode_mod_adder_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           conv,
    input logic [N-1:0]   x2,
    input logic [N-1:0]   y2,
    input logic [N-1:0]   x3,
    input logic           x3_nz,
    input logic [N-1:0]   y3,
    input logic           y3_nz,
    input logic [2*N-1:0] s_vec,
    input logic [2*N-1:0] c_vec,
    input logic [N-1:0]   lo_q,
    input logic [N-1:0]   hi_q,
    input logic           hi_nz_q
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (lo_q == '0 && hi_q == '0 && !hi_nz_q));

    p_lo_single_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (!conv && x2 != '1 && y2 != '1) |=> (lo_q != '1));

    p_d1_both_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!conv && !x3_nz && !y3_nz && x3 == '0 && y3 == '0) |=> (!hi_nz_q && hi_q == '0));

    p_d1_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (!conv && !x3_nz && x3 == '0 && y3_nz) |=> (hi_nz_q && hi_q == $past(y3)));

    p_no_all_ones_r5: assert property (@(posedge clk) disable iff (rst)
        (conv && !(s_vec == '1 && c_vec == '1)) |=> ({hi_q, lo_q} != '1));

    p_conv_flag_r6: assert property (@(posedge clk) disable iff (rst)
        conv |=> !hi_nz_q);

endmodule

bind dual_mode_mod_adder dual_mode_mod_adder_chk #(.N(N)) u_chk (.*);

// File: tb/dual_mode_mod_adder_test.sv
module dual_mode_mod_adder_test;
    localparam int N  = 4;
    localparam int M2 = (1 << N) - 1;
    localparam int M3 = (1 << N) + 1;
    localparam int MC = (1 << (2 * N)) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           conv = 1'b0;
    logic [N-1:0]   x2 = '0, y2 = '0, x3 = '0, y3 = '0;
    logic           x3_nz = 1'b0, y3_nz = 1'b0;
    logic [2*N-1:0] s_vec = '0, c_vec = '0;
    logic [N-1:0]   lo_q, hi_q;
    logic           hi_nz_q;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dual_mode_mod_adder #(.N(N)) uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_d1(input int val, output logic [N-1:0] fld, output logic nz);
        nz  = (val != 0);
        fld = (val != 0) ? N'(val - 1) : '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(lo_q == 0 && hi_q == 0 && !hi_nz_q, "R1", {lo_q, hi_q, hi_nz_q}, 0);

        @(negedge clk);
        rst = 1'b0;

        // channel mode sweep: every residue pair, junk on conversion inputs
        for (int i = 0; i < M3; i++) begin
            for (int j = 0; j < M3; j++) begin
                int e2, e3;
                logic [N-1:0] f3;
                @(negedge clk);
                conv  = 1'b0;
                x2    = N'(i % M2);
                y2    = N'(j % M2);
                set_d1(i, x3, x3_nz);
                set_d1(j, y3, y3_nz);
                s_vec = 8'(i * 37 + j * 11);
                c_vec = 8'(j * 53 + 7);
                e2 = ((i % M2) + (j % M2)) % M2;
                e3 = (i + j) % M3;
                f3 = (e3 != 0) ? N'(e3 - 1) : '0;
                @(posedge clk);
                #1;
                check(lo_q == N'(e2), "R2/R7", lo_q, e2);
                check(hi_q == f3 && hi_nz_q == (e3 != 0), "R3/R7",
                      {hi_nz_q, hi_q}, {(e3 != 0), f3});
            end
        end

        // R8: hold until next edge
        @(negedge clk);
        conv = 1'b0; x2 = 4'd3; y2 = 4'd4;
        #2;
        check(lo_q == 4'(((M3 - 1) % M2 + (M3 - 1) % M2) % M2), "R8 hold", lo_q,
              ((M3 - 1) % M2 + (M3 - 1) % M2) % M2);
        @(posedge clk);
        #1;
        check(lo_q == 4'd7, "R8 update", lo_q, 7);

        // conversion mode sweep: every operand pair except both all ones
        for (int a = 0; a <= MC; a++) begin
            for (int b = 0; b <= MC; b++) begin
                int exp;
                logic [2*N-1:0] res;
                if (a == MC && b == MC) continue;
                @(negedge clk);
                conv  = 1'b1;
                s_vec = 8'(a);
                c_vec = 8'(b);
                x3_nz = a[0];
                y3_nz = b[1];
                x2 = '0; y2 = '0; x3 = '0; y3 = '0;
                exp = (a + b) % MC;
                @(posedge clk);
                #1;
                res = {hi_q, lo_q};
                check(res == 8'(exp), "R4", res, exp);
                if (a + b == MC || b == 0)
                    check(res != 8'(MC), "R5", res, exp);
                if (a == b)
                    check(!hi_nz_q, "R6", hi_nz_q, 0);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule